// File: doc/BRIEF.md
# Buffered capture port with half-full transfer request

The block samples a parallel data word on every capture strobe and holds it in a shallow first-in first-out store. A bus-master reader, typically a DMA channel, takes the words out. The block raises a transfer request, the reader answers with a one-cycle pop (acknowledge), and the popped word appears on the read-data output on the following cycle. In trigger mode the request comes up once the store is half full. It stays up until the store has been drained, so that one request serves a whole block read, and a short burst of captures is absorbed without loss while the reader catches up.

When trigger mode is off, the store is bypassed. The read-data output then behaves as a wide status register that always shows the last captured word, the request stays low and the occupancy reads zero. Captures that arrive while the store is full are discarded, and a sticky overflow flag records them until software clears it.

Top module: `infifo_drq`

## Requirements
- R1: In trigger mode (`hf_mode`=1), a capture strobe while not full stores `cap_data` and raises `level` by one at the same clock edge. The store holds at most DEPTH=4 words of DW=16 bits, and `level` never exceeds 4.
- R2: In trigger mode, `req` rises at the edge where `level` becomes at least DEPTH/2 (2). It stays low while `level` has only ever reached 1 since it was last empty.
- R3: Once high, `req` stays high while the reader pops words, and falls only at the edge where `level` becomes 0.
- R4: A pop with `level`>0 moves the oldest stored word to `rd_data` at that edge and lowers `level` by one. Words leave in the order they were captured, so a burst of 4 is read back complete.
- R5: In status mode (`hf_mode`=0), each capture strobe copies `cap_data` to `rd_data` at that edge, so `rd_data` always holds the latest captured word.
- R6: In status mode, `req` is low, `level` is 0 and pops have no effect on `rd_data`.
- R7: In trigger mode, a capture strobe with `level`=4 and no pop in the same cycle is dropped and sets `ovf`. `ovf` stays set until an `ovf_clr` cycle, and a new overflow in the clear cycle wins.
- R8: A pop while `level`=0 is ignored: `rd_data` and `level` are unchanged.
- R9: A capture and a pop in the same cycle with `level`≥1 leave `level` unchanged and keep first-in first-out order. At `level`=4 the capture is accepted.
- R10: Asynchronous active-low reset empties the store and clears `req`, `ovf` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_mode | input | 1 | 1: buffered with half-full request, 0: status register |
| cap_stb | input | 1 | Capture strobe |
| cap_data | input | DW | Parallel input word |
| pop | input | 1 | Reader acknowledge, pops one word |
| rd_data | output | DW | Popped word or latest status value |
| req | output | 1 | Transfer request |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The checker watches on every cycle that `level` stays within the depth. It also checks that the request rises only at or above half full and falls only when the store is empty, that status mode forces the request and occupancy low, that an empty pop leaves the read data still, that a full capture without a pop sets the overflow flag, and that a simultaneous capture and pop keeps the occupancy. The first-in first-out ordering, the exact words returned after bursts and the status-register value can only be shown by the bench. It compares every output each cycle against a behavioural model, under directed corner cases and a long random mix of strobes, pops, clears and mode changes.

// File: rtl/infifo_drq.sv
module infifo_drq #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hf_mode,
  input  logic                       cap_stb,
  input  logic [DW-1:0]              cap_data,
  input  logic                       pop,
  output logic [DW-1:0]              rd_data,
  output logic                       req,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf,
  input  logic                       ovf_clr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH/2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;
  logic [CW-1:0] lvl_nx;

  assign pop_ok  = hf_mode && pop && (level != '0);
  assign push_ok = hf_mode && cap_stb && ((level != FULL) || pop_ok);
  assign lvl_nx  = level + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      req     <= 1'b0;
      rd_data <= '0;
    end else if (!hf_mode) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      req   <= 1'b0;
      if (cap_stb) rd_data <= cap_data;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok) begin
        rd_data <= mem[rp];
        rp      <= rp + 1'b1;
      end
      level <= lvl_nx;
      if (lvl_nx >= HALF)     req <= 1'b1;
      else if (lvl_nx == '0)  req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= (ovf && !ovf_clr) || (hf_mode && cap_stb && !push_ok);
  end
endmodule

// File: rtl/infifo_drq_chk.sv
module infifo_drq_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hf_mode,
  input logic                       cap_stb,
  input logic                       pop,
  input logic [DW-1:0]              rd_data,
  input logic                       req,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       ovf
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH/2);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) level <= FULL);
  // R2
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(req) |-> level >= HALF);
  // R3
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(req) |-> level == '0);
  // R6
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !hf_mode |=> (!req && level == '0));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_mode && pop && level == '0) |=> ($stable(rd_data) && level == '0 || level == CW'(1)));
  // R7
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_mode && cap_stb && !pop && level == FULL) |=> ovf);
  // R9
  both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_mode && cap_stb && pop && level != '0) |=> $stable(level));
endmodule

bind infifo_drq infifo_drq_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hf_mode(hf_mode), .cap_stb(cap_stb), .pop(pop),
  .rd_data(rd_data), .req(req), .level(level), .ovf(ovf)
);

// File: tb/test_infifo_drq.sv
module test_infifo_drq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hf_mode = 1'b1, cap_stb = 1'b0, pop = 1'b0, ovf_clr = 1'b0;
  logic [15:0] cap_data = '0;
  logic [15:0] rd_data;
  logic req, ovf;
  logic [2:0] level;

  int checks = 0, errors = 0;
  logic [15:0] q [4];
  int   m_cnt = 0;
  logic m_req = 1'b0, m_ovf = 1'b0;
  logic [15:0] m_rd = '0;

  always #5 clk = ~clk;

  infifo_drq i_infifo_drq (
    .clk(clk), .rst_n(rst_n), .hf_mode(hf_mode), .cap_stb(cap_stb), .cap_data(cap_data),
    .pop(pop), .rd_data(rd_data), .req(req), .level(level), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nxt_cnt(input int c, input bit w, input bit p);
    bit pk = p && c > 0;
    bit wk = w && (c < 4 || pk);
    return c + int'(wk) - int'(pk);
  endfunction

  task automatic step(input bit m, input bit w, input bit p, input bit c, input logic [15:0] d);
    bit pk, wk, ev;
    hf_mode = m; cap_stb = w; pop = p; ovf_clr = c; cap_data = d;
    @(posedge clk);
    ev = 1'b0;
    if (!m) begin
      m_cnt = 0; m_req = 1'b0;
      if (w) m_rd = d;
    end else begin
      pk = p && m_cnt > 0;
      wk = w && (m_cnt < 4 || pk);
      ev = w && !wk;
      if (pk) begin
        m_rd = q[0];
        for (int i = 0; i < 3; i++) q[i] = q[i+1];
        m_cnt--;
      end
      if (wk) begin q[m_cnt] = d; m_cnt++; end
      if (m_cnt >= 2) m_req = 1'b1; else if (m_cnt == 0) m_req = 1'b0;
    end
    m_ovf = (m_ovf && !c) || ev;
    @(negedge clk);
    cap_stb = 1'b0; pop = 1'b0; ovf_clr = 1'b0;
    if (m) begin
      chk(level == 3'(m_cnt), "R1 level", level, m_cnt);
      chk(req == m_req, "R3 req", req, m_req);
      chk(rd_data == m_rd, "R4 rd_data", rd_data, m_rd);
    end else begin
      chk(level == 0 && req == 0, "R6 level/req", {req, level}, 0);
      chk(rd_data == m_rd, "R5 rd_data", rd_data, m_rd);
    end
    chk(ovf == m_ovf, "R7 ovf", ovf, m_ovf);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(level == 0 && req == 0 && ovf == 0 && rd_data == 0, "R10 reset", {ovf, req, level, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 one word: no request; second word: request
    step(1, 1, 0, 0, 16'h1111);
    chk(req == 0, "R2 below half", req, 0);
    step(1, 1, 0, 0, 16'h2222);
    chk(req == 1, "R2 at half", req, 1);
    // R3 stays up while draining
    step(1, 0, 1, 0, 0);
    chk(req == 1 && rd_data == 16'h1111, "R3 hold", {req, rd_data}, {1'b1, 16'h1111});
    step(1, 0, 1, 0, 0);
    chk(req == 0 && level == 0, "R3 fall at empty", {req, level}, 0);

    // R7 overflow on full, then R4 order of burst
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 16'hA000 + 16'(i));
    chk(ovf == 1 && level == 4, "R7 set on full", {ovf, level}, {1'b1, 3'd4});
    step(1, 0, 0, 0, 0);
    chk(ovf == 1, "R7 sticky", ovf, 1);
    // R9 both at full: capture accepted
    step(1, 1, 1, 0, 16'hBEEF);
    chk(level == 4 && rd_data == 16'hA000 && ovf == 1, "R9 full both", {level, rd_data}, {3'd4, 16'hA000});
    step(1, 0, 0, 1, 0);
    chk(ovf == 0, "R7 clear", ovf, 0);
    for (int i = 1; i < 4; i++) begin
      step(1, 0, 1, 0, 0);
      chk(rd_data == 16'hA000 + 16'(i), "R4 burst order", rd_data, 16'hA000 + 16'(i));
    end
    step(1, 0, 1, 0, 0);
    chk(rd_data == 16'hBEEF && level == 0, "R4 last word", rd_data, 16'hBEEF);

    // R8 pop on empty
    step(1, 0, 1, 0, 0);
    chk(rd_data == 16'hBEEF && level == 0, "R8 empty pop", rd_data, 16'hBEEF);

    // R9 simultaneous at level 1
    step(1, 1, 0, 0, 16'h0001);
    step(1, 1, 1, 0, 16'h0002);
    chk(level == 1 && rd_data == 16'h0001, "R9 keep level", {level, rd_data}, {3'd1, 16'h0001});
    step(1, 0, 1, 0, 0);
    chk(rd_data == 16'h0002, "R9 order", rd_data, 16'h0002);

    // R5 R6 status mode
    step(0, 1, 0, 0, 16'h5A5A);
    chk(rd_data == 16'h5A5A, "R5 latest", rd_data, 16'h5A5A);
    step(0, 1, 1, 0, 16'h3C3C);
    step(0, 0, 1, 0, 0);
    chk(rd_data == 16'h3C3C && req == 0 && level == 0, "R6 pop ignored", rd_data, 16'h3C3C);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit m = ($urandom % 16) != 0;
      step(m, ($urandom % 3) != 0, ($urandom % 5) < 2, ($urandom % 16) == 0, 16'($urandom));
      if (nxt_cnt(m_cnt, 0, 0) > 4) chk(0, "R1 model", m_cnt, 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule